// File: doc/BRIEF.md
# Interrupt Vector Mask and Pending Tracker

This block sits between an application's interrupt sources and the transmit path of a serial link controller that raises interrupts as message writes. Each of up to 32 vectors has a mask bit, written by the host, and a pending bit. When an interrupt request arrives for an enabled vector, the block checks that vector's mask at that moment. A masked request is held as pending and produces no message. An unmasked request is queued for a message.

Queued vectors leave through a registered valid/ready output, one vector per message, lowest number first. Clearing a mask bit while its pending bit is set queues a single message for that vector and clears the pending bit. Software may also drop pending bits with a write-one-to-clear port, for example when the source was serviced while the vector was still masked.

Top module: `msi_mask_tracker`

## Requirements
- R1: A request on an enabled vector whose mask bit is 1 sets that vector's pending bit on the next clock edge and queues no message.
- R2: A request on an enabled vector whose mask bit is 0 leaves that vector's pending bit at 0 and presents the vector on the message output two clock edges after the request is sampled.
- R3: A write on the clear port clears every pending bit whose data bit is 1 on the next clock edge and leaves the other pending bits unchanged.
- R4: After reset the mask, pending and message-valid outputs are all 0. A mask write takes effect on the next clock edge and is read back unchanged on the mask output.
- R5: Writing a 0 to a mask bit whose pending bit is 1 clears that pending bit on the next edge and produces exactly one message for that vector one edge later.
- R6: When several vectors are queued, messages go out one at a time in ascending vector order. A presented vector and its valid stay unchanged until the handshake completes with valid and ready both high.
- R7: A request whose vector number is greater than or equal to the enabled vector count input changes no pending bit and produces no message.
- R8: If a masked request and a clear write target the same vector in the same cycle, the pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vec_count_i | input | 6 | Number of enabled vectors (0 to 32) |
| mask_we_i | input | 1 | Host mask write strobe |
| mask_wdata_i | input | 32 | New mask value, bit n masks vector n |
| mask_o | output | 32 | Current mask register |
| irq_valid_i | input | 1 | Application interrupt request, one per cycle |
| irq_vec_i | input | 5 | Vector number of the request |
| pend_clr_we_i | input | 1 | Pending clear strobe |
| pend_clr_data_i | input | 32 | Bit n set clears pending bit n |
| pending_o | output | 32 | Current pending register |
| msg_valid_o | output | 1 | A message request is presented |
| msg_vec_o | output | 5 | Vector of the presented message |
| msg_ready_i | input | 1 | Transmit side accepts the message |

## Verification
Mask, pending and clear effects are due one clock edge after the input is sampled, so the bench drives on the falling edge and reads those registers at the next falling edge. A message needs two edges: one to queue the vector and one to load it into the output register, so the bench checks for it one falling edge later than the pending bits. With ready held high, each further queued vector appears one edge after the previous one is taken. The stall test holds ready low and reads the output at several falling edges to confirm it does not move.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int unsigned MSI_MAX_VEC = 32;

  function automatic logic [MSI_MAX_VEC-1:0] vec_onehot(input logic [$clog2(MSI_MAX_VEC)-1:0] v,
                                                        input logic en);
    vec_onehot = '0;
    if (en) vec_onehot[v] = 1'b1;
  endfunction
endpackage

// File: rtl/msi_lowest_pick.sv
module msi_lowest_pick #(
  parameter int unsigned N   = 32,
  localparam int unsigned W  = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] idx_o,
  output logic [N-1:0] oh_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end

  assign any_o = |req_i;
  assign oh_o  = any_o ? (N'(1) << idx_o) : '0;
endmodule

// File: rtl/msi_vec_regs.sv
module msi_vec_regs #(
  parameter int unsigned N  = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_wdata_i,
  input  logic [N-1:0] req_oh_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_data_i,
  input  logic [N-1:0] taken_oh_i,
  output logic [N-1:0] mask_q_o,
  output logic [N-1:0] pend_q_o,
  output logic [N-1:0] send_q_o
);
  logic [N-1:0] msk_req, unm_req, unmask_fire, clr_vec;
  logic [N-1:0] mask_d, pend_d, send_d;

  // request decision uses the mask as it stands this cycle
  assign msk_req = req_oh_i & mask_q_o;
  assign unm_req = req_oh_i & ~mask_q_o;
  assign mask_d  = mask_we_i ? mask_wdata_i : mask_q_o;
  assign clr_vec = clr_we_i ? clr_data_i : '0;

  assign unmask_fire = (pend_q_o | msk_req) & mask_q_o & ~mask_d;

  assign pend_d = ((pend_q_o & ~clr_vec) | msk_req) & ~unmask_fire & ~unm_req;
  assign send_d = (send_q_o & ~taken_oh_i) | unm_req | unmask_fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q_o <= '0;
      pend_q_o <= '0;
      send_q_o <= '0;
    end else begin
      mask_q_o <= mask_d;
      pend_q_o <= pend_d;
      send_q_o <= send_d;
    end
  end
endmodule

// File: rtl/msi_mask_tracker.sv
module msi_mask_tracker
  import msi_pkg::*;
#(
  parameter int unsigned NUM_VEC = MSI_MAX_VEC,
  localparam int unsigned VEC_W  = $clog2(NUM_VEC),
  localparam int unsigned CNT_W  = VEC_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CNT_W-1:0]   vec_count_i,
  input  logic               mask_we_i,
  input  logic [NUM_VEC-1:0] mask_wdata_i,
  output logic [NUM_VEC-1:0] mask_o,
  input  logic               irq_valid_i,
  input  logic [VEC_W-1:0]   irq_vec_i,
  input  logic               pend_clr_we_i,
  input  logic [NUM_VEC-1:0] pend_clr_data_i,
  output logic [NUM_VEC-1:0] pending_o,
  output logic               msg_valid_o,
  output logic [VEC_W-1:0]   msg_vec_o,
  input  logic               msg_ready_i
);
  logic               req_ok;
  logic [NUM_VEC-1:0] req_oh, send_q, taken_oh, pick_oh;
  logic               pick_any, load;
  logic [VEC_W-1:0]   pick_idx;
  logic               out_valid_q;
  logic [VEC_W-1:0]   out_vec_q;

  assign req_ok = irq_valid_i && ({1'b0, irq_vec_i} < vec_count_i);

  always_comb begin
    req_oh = '0;
    if (req_ok) req_oh[irq_vec_i] = 1'b1;
  end

  msi_vec_regs #(.N(NUM_VEC)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mask_we_i    (mask_we_i),
    .mask_wdata_i (mask_wdata_i),
    .req_oh_i     (req_oh),
    .clr_we_i     (pend_clr_we_i),
    .clr_data_i   (pend_clr_data_i),
    .taken_oh_i   (taken_oh),
    .mask_q_o     (mask_o),
    .pend_q_o     (pending_o),
    .send_q_o     (send_q)
  );

  msi_lowest_pick #(.N(NUM_VEC)) u_pick (
    .req_i (send_q),
    .any_o (pick_any),
    .idx_o (pick_idx),
    .oh_o  (pick_oh)
  );

  // output slot refills when empty or when its message is taken
  assign load     = !out_valid_q || msg_ready_i;
  assign taken_oh = load ? pick_oh : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_vec_q   <= '0;
    end else if (load) begin
      out_valid_q <= pick_any;
      out_vec_q   <= pick_idx;
    end
  end

  assign msg_valid_o = out_valid_q;
  assign msg_vec_o   = out_vec_q;
endmodule

// File: rtl/msi_mask_tracker_chk.sv
module msi_mask_tracker_chk #(
  parameter int unsigned NUM_VEC = 32,
  localparam int unsigned VEC_W  = $clog2(NUM_VEC),
  localparam int unsigned CNT_W  = VEC_W + 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [CNT_W-1:0]   vec_count_i,
  input logic               mask_we_i,
  input logic [NUM_VEC-1:0] mask_wdata_i,
  input logic [NUM_VEC-1:0] mask_o,
  input logic               irq_valid_i,
  input logic [VEC_W-1:0]   irq_vec_i,
  input logic               pend_clr_we_i,
  input logic [NUM_VEC-1:0] pend_clr_data_i,
  input logic [NUM_VEC-1:0] pending_o,
  input logic               msg_valid_o,
  input logic [VEC_W-1:0]   msg_vec_o,
  input logic               msg_ready_i
);
  logic in_rng;
  assign in_rng = {1'b0, irq_vec_i} < vec_count_i;

  a_r1_masked_sets_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_i && in_rng && mask_o[irq_vec_i] && !mask_we_i |=> pending_o[$past(irq_vec_i)]);

  a_r2_unmasked_no_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_i && in_rng && !mask_o[irq_vec_i] |=> !pending_o[$past(irq_vec_i)]);

  a_r4_mask_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> mask_o == $past(mask_wdata_i));

  a_r6_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_vec_o));

  a_r7_out_of_range_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_i && !in_rng && !mask_we_i && !pend_clr_we_i |=> $stable(pending_o));

  a_r3_clear_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_clr_we_i && !irq_valid_i && !mask_we_i |=> (pending_o & $past(pend_clr_data_i)) == '0);
endmodule

bind msi_mask_tracker msi_mask_tracker_chk #(.NUM_VEC(NUM_VEC)) u_chk (.*);

// File: tb/msi_mask_tracker_tb.sv
module msi_mask_tracker_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  vec_count_i = 6'd32;
  logic        mask_we_i = 1'b0;
  logic [31:0] mask_wdata_i = '0;
  logic [31:0] mask_o;
  logic        irq_valid_i = 1'b0;
  logic [4:0]  irq_vec_i = '0;
  logic        pend_clr_we_i = 1'b0;
  logic [31:0] pend_clr_data_i = '0;
  logic [31:0] pending_o;
  logic        msg_valid_o;
  logic [4:0]  msg_vec_o;
  logic        msg_ready_i = 1'b1;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_pend;

  always #2.5 clk_i = ~clk_i;

  msi_mask_tracker u_dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic set_mask(input logic [31:0] m);
    mask_we_i = 1'b1; mask_wdata_i = m;
    step();
    mask_we_i = 1'b0;
  endtask

  task automatic request(input int v);
    irq_valid_i = 1'b1; irq_vec_i = 5'(v);
    step();
    irq_valid_i = 1'b0;
  endtask

  task automatic clear(input logic [31:0] d);
    pend_clr_we_i = 1'b1; pend_clr_data_i = d;
    step();
    pend_clr_we_i = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none

    step(); step();
    rst_ni = 1'b1;
    step();
    // R4 reset state
    chk(mask_o == 0 && pending_o == 0 && !msg_valid_o, "R4 reset", {mask_o, pending_o}, 0);

    // R4 mask write and readback
    set_mask(32'hA5C3_0F81);
    chk(mask_o == 32'hA5C3_0F81, "R4 readback", mask_o, 32'hA5C3_0F81);

    // R1 sweep: all masked
    set_mask('1);
    exp_pend = '0;
    for (int v = 0; v < 32; v++) begin
      request(v);
      exp_pend[v] = 1'b1;
      chk(pending_o == exp_pend, "R1 pending", pending_o, exp_pend);
      chk(!msg_valid_o, "R1 no msg", msg_valid_o, 0);
    end
    step();
    chk(!msg_valid_o, "R1 no msg late", msg_valid_o, 0);

    // R3 partial and full clears
    clear(32'h0000_FFFF);
    chk(pending_o == 32'hFFFF_0000, "R3 partial", pending_o, 32'hFFFF_0000);
    clear('1);
    chk(pending_o == 0, "R3 full", pending_o, 0);

    // R2 sweep: all unmasked
    set_mask('0);
    for (int v = 0; v < 32; v++) begin
      request(v);
      chk(pending_o == 0, "R2 pending", pending_o, 0);
      step();
      chk(msg_valid_o && msg_vec_o == 5'(v), "R2 msg", {msg_valid_o, msg_vec_o}, {1'b1, 5'(v)});
    end
    step();
    chk(!msg_valid_o, "R2 drained", msg_valid_o, 0);

    // R5 unmask with pending
    set_mask(32'h0000_0010);
    request(4);
    chk(pending_o == 32'h10, "R5 pending set", pending_o, 32'h10);
    set_mask('0);
    chk(pending_o == 0 && !msg_valid_o, "R5 pending cleared", pending_o, 0);
    step();
    chk(msg_valid_o && msg_vec_o == 5'd4, "R5 msg", msg_vec_o, 4);
    step();
    chk(!msg_valid_o, "R5 single msg", msg_valid_o, 0);

    // R6 ordering and stall
    set_mask('1);
    request(9); request(2); request(5);
    msg_ready_i = 1'b0;
    set_mask('0);
    for (int k = 0; k < 3; k++) begin
      step();
      chk(msg_valid_o && msg_vec_o == 5'd2, "R6 hold", msg_vec_o, 2);
    end
    msg_ready_i = 1'b1;
    step();
    chk(msg_valid_o && msg_vec_o == 5'd5, "R6 order 2nd", msg_vec_o, 5);
    step();
    chk(msg_valid_o && msg_vec_o == 5'd9, "R6 order 3rd", msg_vec_o, 9);
    step();
    chk(!msg_valid_o, "R6 drained", msg_valid_o, 0);

    // R7 out of range with 8 enabled vectors
    vec_count_i = 6'd8;
    set_mask('1);
    for (int v = 8; v < 32; v++) begin
      request(v);
      chk(pending_o == 0, "R7 masked ignored", pending_o, 0);
    end
    request(7);
    chk(pending_o == 32'h80, "R7 top in range", pending_o, 32'h80);
    clear('1);
    set_mask('0);
    request(20);
    step();
    chk(!msg_valid_o && pending_o == 0, "R7 unmasked ignored", msg_valid_o, 0);
    vec_count_i = 6'd0;
    request(0);
    step();
    chk(!msg_valid_o && pending_o == 0, "R7 zero count", msg_valid_o, 0);
    vec_count_i = 6'd32;

    // R8 same-cycle masked request and clear
    set_mask(32'h8);
    request(3);
    irq_valid_i = 1'b1; irq_vec_i = 5'd3;
    pend_clr_we_i = 1'b1; pend_clr_data_i = 32'h8;
    step();
    irq_valid_i = 1'b0; pend_clr_we_i = 1'b0;
    chk(pending_o == 32'h8, "R8 set wins", pending_o, 32'h8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule